// File: doc/BRIEF.md
# Half-Rate Interleaved PRBS-7 Generator

This block produces a maximal-length pseudo-random bit stream of period 127 at one bit per clock cycle, while its seven-bit state register only advances on every second cycle. The state is kept as two interleaved chains, one holding the even-aged history bits and the other the odd-aged ones. Each core step computes two new bits with feedback that crosses between the chains. A 2:1 output selector then hands the two bits out on consecutive cycles, so the serial stream runs at the full rate. The same pair is also presented as a two-bit word with a one-cycle valid strobe.

After reset the block stays idle with all outputs low. A synchronous start pulse loads an all-ones seed, and the stream begins on the next cycle. A new start pulse at any point restarts the stream from its first bit. Typical uses are link self-test, serializer bring-up and as a pattern source for checking a receiver.

Top module: `prbs7_halfrate_gen`

## Requirements
- R1: After reset, serial_o, word_o and valid_o are 0 and stay 0 until start_i is sampled high.
- R2: The cycle after start_i is sampled high (and then low), serial_o carries s[0]. Each following cycle carries the next bit: k cycles after the start edge, serial_o = s[k-1].
- R3: The sequence obeys s[n] = s[n-6] XOR s[n-7], which is the m-sequence of x^7 + x^6 + 1. The seven bits before s[0] are taken as all ones, so s[0..6] = 0,0,0,0,0,0,1.
- R4: Any 127 consecutive serial bits contain exactly 64 ones and 63 zeros.
- R5: valid_o is high on the first cycle after start and then on every second cycle. It is never high on two cycles in a row.
- R6: When valid_o is high, word_o[0] equals serial_o in that cycle and word_o[1] equals serial_o in the next cycle. word_o holds its value until the next valid cycle.
- R7: A start pulse in the middle of a run, on either phase, restarts the stream at s[0] with R2 timing.
- R8: While start_i is held high, serial_o, word_o and valid_o are 0. The stream starts at s[0] on the cycle after start_i is released.
- R9: The state never becomes all zero while running, so serial_o never shows more than six zeros in a row. If an all-zero state is ever found at a core step, the next step reloads the all-ones seed.
- R10: The stream wraps at 127 bits with no dropped or repeated bit: s[n+127] = s[n] for the whole run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Synchronous seed load and sequence start |
| serial_o | output | 1 | Full-rate serial PRBS bit |
| word_o | output | 2 | Bit pair of the latest core step; bit 0 is the earlier one |
| valid_o | output | 1 | High on the cycle a new word_o appears |

## Verification
The serial output is compared bit by bit against a serial reference LFSR over two full periods after a clean start. This shows that the two-bit lookahead and the chain split reproduce the full-rate sequence, including across the wrap. Restart pulses on odd and even phases tell whether the phase counter and the seed load are tied correctly to the start edge. A held start separates a level-sensitive clear from an edge-triggered one. The balance count and the longest zero run check the m-sequence properties on their own, apart from the reference model.

// File: rtl/prbs_hr_pkg.sv
package prbs_hr_pkg;
  localparam int unsigned DEF_LEN = 7;
  localparam int unsigned DEF_TAP = 6;

  typedef enum logic {
    PH_STEP = 1'b0,
    PH_HOLD = 1'b1
  } phase_e;
endpackage

// File: rtl/prbs_hr_chain.sv
module prbs_hr_chain #(
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [DEPTH-1:0] seed_i,
  input  logic             din_i,
  output logic [DEPTH-1:0] q_o
);
  logic [DEPTH-1:0] q_q;

  // q_q[0] newest entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (load_i) q_q <= seed_i;
    else if (en_i)   q_q <= {q_q[DEPTH-2:0], din_i};
  end

  assign q_o = q_q;
endmodule

// File: rtl/prbs_hr_fb.sv
module prbs_hr_fb #(
  parameter int unsigned LEN = 7,
  parameter int unsigned TAP = 6
) (
  input  logic [LEN-1:0] hist_i,
  output logic           bit_a_o,
  output logic           bit_b_o
);
  // hist_i[k] = bit produced k+1 bits ago; a is next bit, b the one after
  always_comb begin
    bit_a_o = hist_i[TAP-1] ^ hist_i[LEN-1];
    bit_b_o = hist_i[TAP-2] ^ hist_i[TAP-1];
  end
endmodule

// File: rtl/prbs_hr_outmux.sv
module prbs_hr_outmux (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       step_i,
  input  logic       bit_a_i,
  input  logic       bit_b_i,
  output logic       serial_o,
  output logic [1:0] word_o,
  output logic       valid_o
);
  logic [1:0] word_q;
  logic       valid_q;
  logic       serial_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q   <= '0;
      valid_q  <= 1'b0;
      serial_q <= 1'b0;
    end else if (clear_i) begin
      word_q   <= '0;
      valid_q  <= 1'b0;
      serial_q <= 1'b0;
    end else if (step_i) begin
      word_q   <= {bit_b_i, bit_a_i};
      valid_q  <= 1'b1;
      serial_q <= bit_a_i;
    end else begin
      valid_q  <= 1'b0;
      serial_q <= word_q[1];
    end
  end

  assign serial_o = serial_q;
  assign word_o   = word_q;
  assign valid_o  = valid_q;

  p_valid_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  p_word_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (serial_q == word_q[0]));

  p_word_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !clear_i) |=> (serial_q == $past(word_q[1])) && $stable(word_q));
endmodule

// File: rtl/prbs7_halfrate_gen.sv
module prbs7_halfrate_gen
  import prbs_hr_pkg::*;
#(
  parameter int unsigned LFSR_LEN = DEF_LEN,
  parameter int unsigned TAP      = DEF_TAP
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic       serial_o,
  output logic [1:0] word_o,
  output logic       valid_o
);
  localparam int unsigned EVEN_D = (LFSR_LEN + 1) / 2;
  localparam int unsigned ODD_D  = LFSR_LEN / 2;

  logic              run_q;
  phase_e            ph_q;
  logic              step;
  logic              zero_state;
  logic              chain_load;
  logic              bit_a;
  logic              bit_b;
  logic [EVEN_D-1:0] even_q;
  logic [ODD_D-1:0]  odd_q;
  logic [LFSR_LEN-1:0] hist;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ph_q  <= PH_STEP;
    end else if (start_i) begin
      run_q <= 1'b1;
      ph_q  <= PH_STEP;
    end else if (run_q) begin
      ph_q  <= (ph_q == PH_STEP) ? PH_HOLD : PH_STEP;
    end
  end

  assign step       = run_q && (ph_q == PH_STEP) && !start_i;
  assign zero_state = (hist == '0);
  assign chain_load = start_i || (step && zero_state);

  // interleave: even ages in one chain, odd ages in the other
  for (genvar k = 0; k < LFSR_LEN; k++) begin : g_hist
    if (k % 2 == 0) begin : g_even
      assign hist[k] = even_q[k/2];
    end else begin : g_odd
      assign hist[k] = odd_q[k/2];
    end
  end

  prbs_hr_fb #(.LEN(LFSR_LEN), .TAP(TAP)) u_fb (
    .hist_i  (hist),
    .bit_a_o (bit_a),
    .bit_b_o (bit_b)
  );

  // newest bit b enters even chain, a enters odd chain
  prbs_hr_chain #(.DEPTH(EVEN_D)) u_even (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (step),
    .load_i (chain_load),
    .seed_i ({EVEN_D{1'b1}}),
    .din_i  (bit_b),
    .q_o    (even_q)
  );

  prbs_hr_chain #(.DEPTH(ODD_D)) u_odd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (step),
    .load_i (chain_load),
    .seed_i ({ODD_D{1'b1}}),
    .din_i  (bit_a),
    .q_o    (odd_q)
  );

  prbs_hr_outmux u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (start_i),
    .step_i   (step),
    .bit_a_i  (bit_a),
    .bit_b_i  (bit_b),
    .serial_o (serial_o),
    .word_o   (word_o),
    .valid_o  (valid_o)
  );

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (!serial_o && !valid_o && word_o == 2'b00));

  p_start_seed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (hist == {LFSR_LEN{1'b1}}) && !valid_o);

  p_state_live_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> !zero_state);

  p_valid_phase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> valid_o);
endmodule

// File: tb/prbs7_halfrate_gen_test.sv
`timescale 1ns/1ps
module prbs7_halfrate_gen_test;
  logic       clk;
  logic       rst_n;
  logic       start;
  logic       serial;
  logic [1:0] word;
  logic       valid;

  int checks = 0;
  int errors = 0;
  logic seq [0:399];
  logic cap [0:299];

  prbs7_halfrate_gen uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .serial_o (serial),
    .word_o   (word),
    .valid_o  (valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic build_ref();
    logic [6:0] h = 7'h7f;
    for (int n = 0; n < 400; n++) begin
      logic nb;
      nb = h[5] ^ h[6];
      seq[n] = nb;
      h = {h[5:0], nb};
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      chk("R1", {serial, valid, word}, 0, "idle outputs");
    end
  endtask

  task automatic t_stream();
    int bad = 0;
    int bad_wrap = 0;
    pulse_start();
    for (int k = 0; k < 260; k++) begin
      @(posedge clk); #1;
      cap[k] = serial;
      if (serial !== seq[k]) bad++;
    end
    chk("R2", int'(cap[0]), int'(seq[0]), "first bit after start");
    chk("R3", bad, 0, "mismatches vs reference over 260 bits");
    for (int k = 0; k < 7; k++)
      chk("R3", int'(cap[k]), (k == 6) ? 1 : 0, "leading bits");
    for (int k = 0; k < 133; k++)
      if (cap[k] !== cap[k+127]) bad_wrap++;
    chk("R10", bad_wrap, 0, "period-127 wrap mismatches");
  endtask

  task automatic t_balance();
    int ones;
    int run0 = 0;
    int max0 = 0;
    for (int s = 0; s < 3; s++) begin
      ones = 0;
      for (int k = s * 40; k < s * 40 + 127; k++) ones += int'(cap[k]);
      chk("R4", ones, 64, "ones in 127-bit window");
    end
    for (int k = 0; k < 260; k++) begin
      run0 = cap[k] ? 0 : run0 + 1;
      if (run0 > max0) max0 = run0;
    end
    chk("R9", max0, 6, "longest zero run");
  endtask

  task automatic t_valid_word();
    int vbad = 0;
    int wbad = 0;
    logic [1:0] held;
    pulse_start();
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      if (valid !== ((k % 2) == 0)) vbad++;
      if (valid) begin
        held = word;
        if (word[0] !== seq[k] || word[1] !== seq[k+1]) wbad++;
      end else if (word !== held) wbad++;
    end
    chk("R5", vbad, 0, "valid pattern errors");
    chk("R6", wbad, 0, "word content errors");
  endtask

  task automatic t_restart(input int offset);
    int bad = 0;
    pulse_start();
    for (int k = 0; k < offset; k++) @(posedge clk);
    pulse_start();
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); #1;
      if (serial !== seq[k] || valid !== ((k % 2) == 0)) bad++;
    end
    chk("R7", bad, 0, $sformatf("restart after %0d cycles", offset));
  endtask

  task automatic t_start_hold();
    int bad = 0;
    @(negedge clk) start = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk("R8", {serial, valid, word}, 0, "outputs while start held");
    end
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1;
      if (serial !== seq[k]) bad++;
    end
    chk("R8", bad, 0, "stream after start release");
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    build_ref();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stream();
    t_balance();
    t_valid_word();
    t_restart(37);
    t_restart(50);
    t_start_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule